// File: doc/BRIEF.md
# Masked next-active-element finder

This block walks a 64-element predicate mask and reports the next active element at each step. Software-visible vector loops that skip masked-out elements use it. A load captures the mask together with a vector length. Element positions at or above that length are treated as set, so every search stops at the vector length. The block then reports how many inactive elements lie between the current search position and the next active one, together with that element's absolute index.

The search is a logarithmic cascade of test-and-shift stages. The first stage checks the low 32 bits of the working register for all zeros. If they are all zero, it shifts the register down by 32 and fills ones in at the top. Further stages do the same with 16, 8, 4, 2 and 1 bits. Each stage's shift decision supplies one bit of the zero count. The shifted value leaving the cascade, moved down by one more place to consume the found element, becomes the next register state. An advance therefore yields a new result on the very next cycle.

A small controller has three states. IDLE is the state after reset, with no mask held. SEEK holds a mask and presents a result. DRAINED means no active element remains below the vector length. Transitions: a load moves any state to SEEK. In SEEK, a search that finds no active element below the vector length moves to DRAINED. An advance in SEEK with a valid result stays in SEEK and consumes the element. IDLE and DRAINED hold until the next load.

Top module: `mask_step_finder`

## Requirements
- R1: After reset, valid_o and empty_o are low and count_o and index_o are zero.
- R2: A load captures mask_i, where bit i set means element i is active. It uses vl_i as the vector length, and any vl_i above 64 is taken as 64. The search position restarts at element 0, and the first result appears on the cycle after the load.
- R3: While valid_o is high, index_o is the lowest active element index that is at or above the search position and below the vector length. count_o equals index_o minus the search position.
- R4: An advance while valid_o is high moves the search position to index_o + 1. The next result appears on the following cycle with no idle cycle in between.
- R5: Mask bits at or above the vector length have no effect. When no active element lies between the search position and the vector length, empty_o is high, valid_o is low, and count_o and index_o are zero. This includes a vector length of 0 and an all-zero mask.
- R6: Once empty_o is high, it stays high and advances are ignored until the next load.
- R7: An advance in IDLE changes nothing. Without an advance, a valid result is held unchanged.
- R8: When load and advance are high in the same cycle, the load wins and the search restarts at element 0.
- R9: valid_o and empty_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture a new mask and vector length |
| mask_i | input | 64 | Predicate mask, bit i set = element i active |
| vl_i | input | 7 | Vector length (values above 64 act as 64) |
| advance_i | input | 1 | Consume the current active element |
| count_o | output | 6 | Inactive elements skipped before the current result |
| index_o | output | 6 | Absolute index of the current active element |
| valid_o | output | 1 | count_o and index_o describe an active element |
| empty_o | output | 1 | No active element remains below the vector length |

## Verification
The hardest situations to reach are the edges of the cascade. One is an all-zero mask with a full vector length, where every stage shifts and the final bit is still clear. Another is a walk that reaches element 63 and then has to report exhaustion, while mask bits above a short vector length must stay invisible. Directed loads build these cases: an empty mask at length 64, a lone bit at element 63 with an oversized length, a vector length of zero, and set bits just beyond the length. Random loads with sparse, dense and full masks, together with random advance and reload patterns, cover walks that cross stage boundaries at many different offsets.

// File: rtl/mask_step_pkg.sv
package mask_step_pkg;

    // controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEEK    = 2'd1,
        ST_DRAINED = 2'd2
    } step_state_t;

endpackage

// File: rtl/mask_step_loader.sv
// Builds the working register from an incoming mask: element positions at or
// above the vector length read as active so that every search halts there.
module mask_step_loader #(
    parameter int MASK_W = 64,
    parameter int VL_W   = 7
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [VL_W-1:0]   vl_i,
    output logic [MASK_W-1:0] work_o
);

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign work_o[i] = (VL_W'(i) < vl_i) ? mask_i[i] : 1'b1;
    end

endmodule

// File: rtl/mask_step_stage.sv
// One test-and-shift step: if the low SHIFT bits are all clear, drop them and
// feed ones in at the top.
module mask_step_stage #(
    parameter int MASK_W = 64,
    parameter int SHIFT  = 32
) (
    input  logic [MASK_W-1:0] din,
    output logic [MASK_W-1:0] dout,
    output logic              took
);

    assign took = ~|din[SHIFT-1:0];
    assign dout = took ? {{SHIFT{1'b1}}, din[MASK_W-1:SHIFT]} : din;

endmodule

// File: rtl/mask_step_cascade.sv
// Logarithmic chain of stages; stage s shifts by MASK_W >> (s+1) and its
// decision is bit (LVL-1-s) of the zero count.
module mask_step_cascade #(
    parameter int MASK_W = 64,
    localparam int LVL   = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] work_i,
    output logic [LVL-1:0]    zeros_o,
    output logic [MASK_W-1:0] rest_o,
    output logic              none_o
);

    logic [MASK_W-1:0] chain [0:LVL];

    assign chain[0] = work_i;

    for (genvar s = 0; s < LVL; s++) begin : g_stage
        mask_step_stage #(
            .MASK_W (MASK_W),
            .SHIFT  (MASK_W >> (s + 1))
        ) u_stage (
            .din  (chain[s]),
            .dout (chain[s+1]),
            .took (zeros_o[LVL-1-s])
        );
    end

    // bit 0 of the result is the found element; clear means nothing was set
    assign rest_o = chain[LVL];
    assign none_o = ~chain[LVL][0];

endmodule

// File: rtl/mask_step_finder.sv
module mask_step_finder
    import mask_step_pkg::*;
#(
    parameter int MASK_W = 64,
    localparam int IDX_W = $clog2(MASK_W),
    localparam int VL_W  = IDX_W + 1,
    localparam int POS_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              advance_i,
    output logic [IDX_W-1:0]  count_o,
    output logic [IDX_W-1:0]  index_o,
    output logic              valid_o,
    output logic              empty_o
);

    step_state_t       state_q, state_d;
    logic [MASK_W-1:0] work_q;
    logic [VL_W-1:0]   vl_q;
    logic [POS_W-1:0]  base_q;

    logic [VL_W-1:0]   vl_eff;
    logic [MASK_W-1:0] work_ld;
    logic [IDX_W-1:0]  zeros;
    logic [MASK_W-1:0] rest;
    logic              none;
    logic [POS_W-1:0]  hit_pos;
    logic              at_end;
    logic              consume;

    assign vl_eff = (vl_i > VL_W'(MASK_W)) ? VL_W'(MASK_W) : vl_i;

    mask_step_loader #(
        .MASK_W (MASK_W),
        .VL_W   (VL_W)
    ) u_loader (
        .mask_i (mask_i),
        .vl_i   (vl_eff),
        .work_o (work_ld)
    );

    mask_step_cascade #(
        .MASK_W (MASK_W)
    ) u_cascade (
        .work_i  (work_q),
        .zeros_o (zeros),
        .rest_o  (rest),
        .none_o  (none)
    );

    assign hit_pos = base_q + POS_W'(zeros);
    assign at_end  = none || (hit_pos >= POS_W'(vl_q));
    assign consume = (state_q == ST_SEEK) && !at_end && advance_i && !load_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_SEEK;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SEEK:    state_d = at_end ? ST_DRAINED : ST_SEEK;
                ST_DRAINED: state_d = ST_DRAINED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working register and search base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '1;
            vl_q   <= '0;
            base_q <= '0;
        end else if (load_i) begin
            work_q <= work_ld;
            vl_q   <= vl_eff;
            base_q <= '0;
        end else if (consume) begin
            work_q <= {1'b1, rest[MASK_W-1:1]};
            base_q <= hit_pos + POS_W'(1);
        end
    end

    // outputs
    always_comb begin
        valid_o = 1'b0;
        empty_o = 1'b0;
        count_o = '0;
        index_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEEK: begin
                if (at_end) begin
                    empty_o = 1'b1;
                end else begin
                    valid_o = 1'b1;
                    count_o = zeros;
                    index_o = hit_pos[IDX_W-1:0];
                end
            end
            ST_DRAINED: empty_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mask_step_chk.sv
module mask_step_chk #(
    parameter int IDX_W = 6,
    localparam int VL_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             advance_i,
    input logic             valid_o,
    input logic             empty_o,
    input logic [IDX_W-1:0] count_o,
    input logic [IDX_W-1:0] index_o,
    input logic [VL_W-1:0]  vl_q
);

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && empty_o));

    p_below_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (VL_W'(index_o) < vl_q));

    p_count_le_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_o <= index_o));

    p_empty_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !load_i) |=> empty_o);

    p_advance_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && advance_i && !load_i) |=> (!valid_o || (index_o > $past(index_o))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !advance_i && !load_i) |=>
            (valid_o && $stable(index_o) && $stable(count_o)));

    p_load_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o || empty_o));

    p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !empty_o && !load_i) |=> (!valid_o && !empty_o));

endmodule

bind mask_step_finder mask_step_chk #(
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .advance_i (advance_i),
    .valid_o   (valid_o),
    .empty_o   (empty_o),
    .count_o   (count_o),
    .index_o   (index_o),
    .vl_q      (vl_q)
);

// File: tb/mask_step_finder_tb.sv
`timescale 1ns/1ps
module mask_step_finder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic [6:0]  vl_i = '0;
    logic        advance_i = 1'b0;
    logic [5:0]  count_o, index_o;
    logic        valid_o, empty_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [63:0] m_mask = '0;
    int          m_vl = 0;
    int          m_p = 0;
    bit          m_loaded = 1'b0;

    always #2.5 clk = ~clk;

    mask_step_finder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .mask_i    (mask_i),
        .vl_i      (vl_i),
        .advance_i (advance_i),
        .count_o   (count_o),
        .index_o   (index_o),
        .valid_o   (valid_o),
        .empty_o   (empty_o)
    );

    function automatic int exp_idx();
        for (int i = m_p; i < m_vl; i++)
            if (m_mask[i]) return i;
        return -1;
    endfunction

    task automatic check(input string req);
        int e;
        logic ev, ee;
        logic [5:0] ec, ei;
        e  = exp_idx();
        ev = 1'b0; ee = 1'b0; ec = '0; ei = '0;
        if (m_loaded) begin
            if (e < 0) ee = 1'b1;
            else begin
                ev = 1'b1;
                ec = 6'(e - m_p);
                ei = 6'(e);
            end
        end
        n_chk++;
        if (valid_o !== ev || empty_o !== ee || count_o !== ec || index_o !== ei) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b empty=%0b count=%0d index=%0d, expected valid=%0b empty=%0b count=%0d index=%0d",
                     req, valid_o, empty_o, count_o, index_o, ev, ee, ec, ei);
        end
    endtask

    // one clock cycle: drive at negedge, update model at the edge, check at next negedge
    task automatic step(input logic ld, input logic [63:0] m, input logic [6:0] vl,
                        input logic adv, input string req);
        int e;
        load_i = ld; mask_i = m; vl_i = vl; advance_i = adv;
        e = exp_idx();
        @(posedge clk);
        if (ld) begin
            m_mask = m;
            m_vl = (int'(vl) > 64) ? 64 : int'(vl);
            m_p = 0;
            m_loaded = 1'b1;
        end else if (adv && m_loaded && e >= 0) begin
            m_p = e + 1;
        end
        @(negedge clk);
        load_i = 1'b0;
        advance_i = 1'b0;
        check(req);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        step(0, '0, 7'd0, 1, "R7 advance in idle");
        step(0, '0, 7'd0, 0, "R1 still idle");

        step(1, 64'h1, 7'd64, 0, "R2 load element 0 active");
        step(1, (64'h1 << 3) | (64'h1 << 40) | (64'h1 << 63), 7'd64, 0, "R3 first hit at 3");
        step(0, '0, 7'd0, 1, "R4 advance to 40");
        step(0, '0, 7'd0, 1, "R4 advance to 63");
        step(0, '0, 7'd0, 0, "R7 hold at 63");
        step(0, '0, 7'd0, 1, "R5 exhausted after 63");
        step(0, '0, 7'd0, 1, "R6 advance while empty");
        step(0, '0, 7'd0, 0, "R6 empty persists");

        step(1, 64'h0, 7'd64, 0, "R5 all-zero mask full length");
        step(0, '0, 7'd0, 0, "R6 all-zero stays empty");
        step(1, '1, 7'd0, 0, "R5 zero vector length");
        step(1, (64'h1 << 12) | (64'h1 << 5), 7'd10, 0, "R5 short length hit 5");
        step(0, '0, 7'd0, 1, "R5 bit above length ignored");
        step(1, 64'h1 << 63, 7'd100, 0, "R2 oversize length clamps");

        step(1, 64'hF0F0, 7'd64, 0, "R2 load for priority test");
        step(0, '0, 7'd0, 1, "R4 advance before reload");
        step(1, 64'h8000_0000_0000_0100, 7'd64, 1, "R8 load beats advance");

        step(1, '1, 7'd64, 0, "R4 dense walk start");
        for (int k = 0; k < 64; k++) step(0, '0, 7'd0, 1, "R4 dense walk no bubble");

        for (int t = 0; t < 60; t++) begin
            logic [63:0] m;
            logic [6:0]  vl;
            int mode;
            mode = int'($urandom_range(0, 3));
            case (mode)
                0: m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                1: m = {$urandom, $urandom};
                2: m = 64'h1 << $urandom_range(0, 63);
                default: m = ~(64'h1 << $urandom_range(0, 63));
            endcase
            vl = 7'($urandom_range(0, 72));
            step(1, m, vl, 1'($urandom_range(0, 1)), "R2 random load");
            for (int k = 0; k < 40; k++) begin
                int r;
                r = int'($urandom_range(0, 19));
                if (r == 0)
                    step(1, {$urandom, $urandom}, 7'($urandom_range(0, 64)), 1'($urandom_range(0, 1)), "R8 random reload");
                else
                    step(0, '0, 7'd0, 1'(r > 4), "R3 random walk");
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule